// File: doc/BRIEF.md
# Guarded Multiply-Accumulate Unit

This unit is the multiply-accumulate element of a 16-bit fixed-point signal-processing datapath. Each clock it forms the product of two 16-bit operands and, depending on a 3-bit command, loads the product into the accumulator, adds it, subtracts it, clears the accumulator, saturates it, or holds it. The accumulator is 40 bits wide. Eight guard bits sit above the 32-bit product range, so long sums can run past the 32-bit range without wrapping.

Each operand carries its own signed/unsigned select. Multiword products can therefore be built from signed-high and unsigned-low partial products. A fractional mode doubles the product, so two 1.15 operands give a 1.31 result. The registered accumulator is presented directly at the output, so another unit can consume it on the next cycle. A combinational output stage gives a 16-bit view of the accumulator. This view can be rounded and is clamped to the 16-bit range.

The command decode is the only control structure. Commands are NOP (hold), MUL (load), MAC (add), MSU (subtract), CLR (zero) and SAT (clamp). Every command takes effect at the next rising clock edge, and the unit returns to the same idle condition afterwards. Unused codes behave like NOP.

Top module: `mac40_unit`

## Requirements
- R1: While rst_n is low, acc_o is 0, ovf_o is 0 and res16_o is 0.
- R2: MUL (op_i = 1) replaces the accumulator with the product at the next rising edge. This is the same as a clear followed by a load in one cycle.
- R3: MAC (op_i = 2) adds the product to the accumulator at the next rising edge.
- R4: MSU (op_i = 3) subtracts the product from the accumulator at the next rising edge.
- R5: CLR (op_i = 4) sets the accumulator to zero at the next rising edge.
- R6: NOP (op_i = 0) and the unused codes 6 and 7 leave the accumulator unchanged, whatever the operand inputs are.
- R7: x_signed_i = 1 reads x_i as two's complement, and x_signed_i = 0 reads it as unsigned. y_signed_i and y_i follow the same rule, independently of x.
- R8: frac_i = 1 doubles the product, which is a shift left by one, before it is used.
- R9: ovf_o is 1 exactly when acc_o bits 39 down to 31 are not all equal, that is, when the value lies outside the signed 32-bit range.
- R10: When ovf_o is 1, SAT (op_i = 5) sets the accumulator to 0x007FFFFFFF if bit 39 is 0, or to 0xFF80000000 if bit 39 is 1. When ovf_o is 0, SAT leaves the accumulator unchanged. After SAT, ovf_o is 0.
- R11: res16_o is bits 31 down to 16 of the accumulator, after 0x8000 is added when round_i is 1. If that sum lies outside the signed 32-bit range, res16_o is 0x7FFF for a positive sum and 0x8000 for a negative one. res16_o follows acc_o and round_i with no register between them.
- R12: Accumulator arithmetic wraps modulo 2^40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Command: 0 NOP, 1 MUL, 2 MAC, 3 MSU, 4 CLR, 5 SAT |
| x_i | input | 16 | First operand |
| y_i | input | 16 | Second operand |
| x_signed_i | input | 1 | 1: x_i is two's complement; 0: x_i is unsigned |
| y_signed_i | input | 1 | 1: y_i is two's complement; 0: y_i is unsigned |
| frac_i | input | 1 | 1: the product is doubled (fractional mode) |
| round_i | input | 1 | 1: 0x8000 is added before the 16-bit view is taken |
| acc_o | output | 40 | Registered accumulator |
| ovf_o | output | 1 | Accumulator lies outside the signed 32-bit range |
| res16_o | output | 16 | Rounded and saturated upper half of the accumulator |

## Verification
On every cycle, the assertions check the effect each command has one edge later: load, add, subtract, clear, hold, and SAT clearing the overflow flag. They also check two standing conditions: an unsigned-by-unsigned product is never negative, and an overflowed accumulator read without rounding always gives a clamped 16-bit view. The bench scenarios are the only place where the numeric side is shown. They cover the mixed-sign products, the fractional doubling of the most negative operand pair, and the exact clamp values. They also cover rounding carrying into the clamp, the wrap of the 40-bit sum after many large unsigned accumulations, and agreement with a behavioural model over a long random sequence.

// File: rtl/mac40_pkg.sv
package mac40_pkg;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_MUL = 3'd1,
        OP_MAC = 3'd2,
        OP_MSU = 3'd3,
        OP_CLR = 3'd4,
        OP_SAT = 3'd5
    } mac_op_e;

endpackage

// File: rtl/mac40_mult.sv
module mac40_mult #(
    parameter int DATA_W  = 16,
    parameter int GUARD_W = 8
) (
    input  logic [DATA_W-1:0]          x_i,
    input  logic [DATA_W-1:0]          y_i,
    input  logic                       x_signed_i,
    input  logic                       y_signed_i,
    input  logic                       frac_i,
    output logic [2*DATA_W+GUARD_W-1:0] prod_o
);
    localparam int EXT_W  = DATA_W + 1;
    localparam int MUL_W  = 2 * EXT_W;
    localparam int PROD_W = 2 * DATA_W;
    localparam int ACC_W  = PROD_W + GUARD_W;
    localparam int PAD_W  = ACC_W - MUL_W;

    logic signed [EXT_W-1:0] x_ext;
    logic signed [EXT_W-1:0] y_ext;
    logic signed [MUL_W-1:0] x_wide;
    logic signed [MUL_W-1:0] y_wide;
    logic signed [MUL_W-1:0] prod_raw;
    logic        [ACC_W-1:0] prod_full;

    // operand sign handling for multiword arithmetic (R7)
    assign x_ext    = {x_signed_i & x_i[DATA_W-1], x_i};
    assign y_ext    = {y_signed_i & y_i[DATA_W-1], y_i};
    assign x_wide   = {{EXT_W{x_ext[EXT_W-1]}}, x_ext};
    assign y_wide   = {{EXT_W{y_ext[EXT_W-1]}}, y_ext};
    assign prod_raw = x_wide * y_wide;

    assign prod_full = {{PAD_W{prod_raw[MUL_W-1]}}, prod_raw};

    // fractional doubling (R8)
    assign prod_o = frac_i ? (prod_full << 1) : prod_full;

    always_comb begin
        if (!x_signed_i && !y_signed_i) begin
            assert_unsigned_pos_R7: assert (prod_o[ACC_W-1] == 1'b0);
        end
    end

endmodule

// File: rtl/mac40_accum.sv
module mac40_accum
    import mac40_pkg::*;
#(
    parameter int PROD_W = 32,
    parameter int ACC_W  = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mac_op_e          op_i,
    input  logic [ACC_W-1:0] prod_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             ovf_o
);
    localparam int TOP_W = ACC_W - PROD_W + 1;
    localparam logic [ACC_W-1:0] POS_LIM = {{TOP_W{1'b0}}, {(PROD_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] NEG_LIM = {{TOP_W{1'b1}}, {(PROD_W-1){1'b0}}};

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_nxt;
    logic             guard_bad;

    // guard bits no longer a sign extension (R9)
    assign guard_bad = !((&acc_q[ACC_W-1:PROD_W-1]) || !(|acc_q[ACC_W-1:PROD_W-1]));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_nxt;
        end
    end

    always_comb begin
        acc_nxt = acc_q;
        unique case (op_i)
            OP_NOP: acc_nxt = acc_q;
            OP_MUL: acc_nxt = prod_i;
            OP_MAC: acc_nxt = acc_q + prod_i;
            OP_MSU: acc_nxt = acc_q - prod_i;
            OP_CLR: acc_nxt = '0;
            OP_SAT: begin
                if (guard_bad) begin
                    acc_nxt = acc_q[ACC_W-1] ? NEG_LIM : POS_LIM;
                end
            end
            default: acc_nxt = acc_q;
        endcase
    end

    assign acc_o = acc_q;
    assign ovf_o = guard_bad;

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_MUL |=> acc_q == $past(prod_i));
    assert_add_R3: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_MAC |=> acc_q == $past(acc_q) + $past(prod_i));
    assert_sub_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_MSU |=> acc_q == $past(acc_q) - $past(prod_i));
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_CLR |=> acc_q == '0);
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_NOP |=> $stable(acc_q));
    assert_sat_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_SAT |=> !ovf_o);

endmodule

// File: rtl/mac40_outstage.sv
module mac40_outstage #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 40
) (
    input  logic [ACC_W-DATA_W:0] acc_hi_i,
    input  logic                  round_i,
    output logic [DATA_W-1:0]     res_o
);
    localparam int HI_W  = ACC_W - DATA_W;
    localparam int SUM_W = HI_W + 1;
    localparam logic [DATA_W-1:0] MAX16 = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] MIN16 = {1'b1, {(DATA_W-1){1'b0}}};

    logic [SUM_W-1:0] upper;
    logic [SUM_W-1:0] sum;
    logic             in_range;

    // bit 0 of acc_hi_i is the half-LSB position of the 16-bit view (R11)
    assign upper    = {acc_hi_i[HI_W], acc_hi_i[HI_W:1]};
    assign sum      = upper + {{HI_W{1'b0}}, round_i & acc_hi_i[0]};
    assign in_range = (&sum[SUM_W-1:DATA_W-1]) || !(|sum[SUM_W-1:DATA_W-1]);

    always_comb begin
        if (in_range) begin
            res_o = sum[DATA_W-1:0];
        end else begin
            res_o = sum[SUM_W-1] ? MIN16 : MAX16;
        end
    end

endmodule

// File: rtl/mac40_unit.sv
module mac40_unit
    import mac40_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int GUARD_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [2:0]                  op_i,
    input  logic [DATA_W-1:0]           x_i,
    input  logic [DATA_W-1:0]           y_i,
    input  logic                        x_signed_i,
    input  logic                        y_signed_i,
    input  logic                        frac_i,
    input  logic                        round_i,
    output logic [2*DATA_W+GUARD_W-1:0] acc_o,
    output logic                        ovf_o,
    output logic [DATA_W-1:0]           res16_o
);
    localparam int PROD_W = 2 * DATA_W;
    localparam int ACC_W  = PROD_W + GUARD_W;

    logic [ACC_W-1:0] prod_w;
    logic [ACC_W-1:0] acc_w;
    mac_op_e          op_w;

    assign op_w = mac_op_e'(op_i);

    mac40_mult #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_mult (
        .x_i        (x_i),
        .y_i        (y_i),
        .x_signed_i (x_signed_i),
        .y_signed_i (y_signed_i),
        .frac_i     (frac_i),
        .prod_o     (prod_w)
    );

    mac40_accum #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_i   (op_w),
        .prod_i (prod_w),
        .acc_o  (acc_w),
        .ovf_o  (ovf_o)
    );

    mac40_outstage #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_out (
        .acc_hi_i (acc_w[ACC_W-1:DATA_W-1]),
        .round_i  (round_i),
        .res_o    (res16_o)
    );

    assign acc_o = acc_w;

    assert_res_clamp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !round_i) |-> (res16_o == {1'b0, {(DATA_W-1){1'b1}}} ||
                                 res16_o == {1'b1, {(DATA_W-1){1'b0}}}));

endmodule

// File: tb/mac40_unit_bench.sv
module mac40_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [15:0] x_i = '0;
    logic [15:0] y_i = '0;
    logic        x_signed_i = 1'b0;
    logic        y_signed_i = 1'b0;
    logic        frac_i = 1'b0;
    logic        round_i = 1'b0;
    logic [39:0] acc_o;
    logic        ovf_o;
    logic [15:0] res16_o;

    int total = 0;
    int bad = 0;
    logic [39:0] model_acc = '0;

    always #4 clk = ~clk;

    mac40_unit u_mac40_unit (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .x_i(x_i), .y_i(y_i),
        .x_signed_i(x_signed_i), .y_signed_i(y_signed_i), .frac_i(frac_i),
        .round_i(round_i), .acc_o(acc_o), .ovf_o(ovf_o), .res16_o(res16_o)
    );

    function automatic longint as_int(logic [39:0] v);
        return longint'($signed(v));
    endfunction

    function automatic logic model_ovf(logic [39:0] v);
        longint s = as_int(v);
        return (s > 64'sd2147483647) || (s < -64'sd2147483648);
    endfunction

    function automatic logic [15:0] model_res(logic [39:0] v, logic rnd);
        longint r = as_int(v) + (rnd ? 64'sd32768 : 64'sd0);
        if (r > 64'sd2147483647) return 16'h7fff;
        if (r < -64'sd2147483648) return 16'h8000;
        return r[31:16];
    endfunction

    task automatic check(string tag, string what, logic [39:0] got, logic [39:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    task automatic check_outputs(string tag);
        check(tag, "acc", acc_o, model_acc);
        check(tag, "ovf", {39'd0, ovf_o}, {39'd0, model_ovf(model_acc)});
        check(tag, "res16", {24'd0, res16_o}, {24'd0, model_res(model_acc, round_i)});
    endtask

    // one clock: apply at negedge, model the edge, compare after it
    task automatic step(string tag, logic [2:0] op, logic [15:0] x, logic [15:0] y,
                        logic xs, logic ys, logic fr, logic rnd);
        longint a;
        longint b;
        longint p;
        op_i = op; x_i = x; y_i = y; x_signed_i = xs; y_signed_i = ys;
        frac_i = fr; round_i = rnd;
        a = xs ? longint'($signed(x)) : longint'(x);
        b = ys ? longint'($signed(y)) : longint'(y);
        p = a * b;
        if (fr) p = p * 2;
        case (op)
            3'd1: model_acc = p[39:0];
            3'd2: model_acc = model_acc + p[39:0];
            3'd3: model_acc = model_acc - p[39:0];
            3'd4: model_acc = '0;
            3'd5: if (model_ovf(model_acc))
                      model_acc = model_acc[39] ? 40'hff80000000 : 40'h007fffffff;
            default: ;
        endcase
        @(posedge clk);
        @(negedge clk);
        check_outputs(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_outputs("R1");
        rst_n = 1'b1;

        // R2 signed load, negative times positive
        step("R2", 3'd1, 16'hfffd, 16'h0007, 1, 1, 0, 0);
        // R3 add
        step("R3", 3'd2, 16'h0100, 16'h0200, 1, 1, 0, 0);
        // R4 subtract to negative
        step("R4", 3'd3, 16'h1000, 16'h1000, 1, 1, 0, 0);
        // R6 NOP and unused codes ignore operand changes
        step("R6", 3'd0, 16'h7fff, 16'h7fff, 1, 1, 1, 0);
        step("R6", 3'd6, 16'h1234, 16'h5678, 0, 0, 0, 0);
        step("R6", 3'd7, 16'hffff, 16'hffff, 0, 0, 1, 1);
        // R5 clear
        step("R5", 3'd4, 16'hffff, 16'hffff, 0, 0, 0, 0);
        // R7 sign selects: unsigned x, signed y, and the reverse
        step("R7", 3'd1, 16'hffff, 16'hffff, 0, 1, 0, 0);
        step("R7", 3'd1, 16'hffff, 16'h8000, 1, 0, 0, 0);
        step("R7", 3'd1, 16'hffff, 16'hffff, 0, 0, 0, 0);
        // R8 fractional: most negative squared overflows 32 bits (R9)
        step("R8", 3'd1, 16'h8000, 16'h8000, 1, 1, 1, 0);
        step("R9", 3'd2, 16'h4000, 16'h4000, 1, 1, 1, 0);
        // R10 saturate positive, then rounding into the clamp (R11)
        step("R10", 3'd5, 16'h0000, 16'h0000, 0, 0, 0, 0);
        step("R11", 3'd0, 16'h0000, 16'h0000, 0, 0, 0, 1);
        step("R10", 3'd5, 16'h0000, 16'h0000, 0, 0, 0, 0);
        // R10 saturate negative
        step("R10", 3'd1, 16'h8000, 16'h7fff, 1, 1, 1, 0);
        step("R10", 3'd3, 16'h7fff, 16'h7fff, 1, 1, 1, 0);
        step("R10", 3'd5, 16'h0000, 16'h0000, 0, 0, 0, 0);
        // R11 rounding at the half-LSB
        step("R11", 3'd1, 16'h0001, 16'h8000, 0, 0, 0, 1);
        step("R11", 3'd1, 16'h0001, 16'h7fff, 0, 0, 0, 1);
        step("R11", 3'd1, 16'hffff, 16'h8000, 1, 0, 0, 1);
        // R12 long unsigned fractional accumulation wraps the 40-bit range
        step("R12", 3'd4, 16'h0000, 16'h0000, 0, 0, 0, 0);
        for (int i = 0; i < 70; i++) begin
            step("R12", 3'd2, 16'hffff, 16'hffff, 0, 0, 1, i[0]);
        end
        // mixed random run against the model, exercising R2 through R11
        for (int i = 0; i < 400; i++) begin
            step("R3", 3'($urandom_range(0, 7)), 16'($urandom), 16'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end
        // R1 reset clears a loaded accumulator
        step("R1", 3'd1, 16'h7fff, 16'h7fff, 1, 1, 0, 0);
        rst_n = 1'b0;
        model_acc = '0;
        op_i = 3'd0;
        round_i = 1'b0;
        #1;
        check_outputs("R1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule